// File: doc/BRIEF.md
# Privileged Interrupt Selector

This block decides, once per clock, whether a hart should take an interrupt and which cause code it reports. It looks at the vector of pending interrupt lines, a delegation mask, the current privilege level, the machine and supervisor global enable bits, and a flag that says the hart is in debug mode. From these it produces a registered take strobe and a cause word. The cause word carries the interrupt marker in its most significant bit and the selected line number in its low bits.

Lines that are not delegated form the machine group. Lines that are delegated form the supervisor group. The machine group is always examined first. The supervisor group is used only when no machine-group line is both pending and enabled. Within the chosen group, the lowest-numbered set line wins.

The block does not redirect the program counter, update any status register or generate the pending bits. Those tasks belong to the surrounding pipeline. The data width is a parameter and may be 32 or 64.

Top module: `irq_select_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, `take_o` becomes 0 and `cause_o` becomes all zeros.
- R2: The machine group is `pend_i & ~deleg_i`. It is enabled when `priv_i` is below machine level, or when `priv_i` is machine level (3) and `m_ie_i` is 1. Privilege is encoded as user=0, supervisor=1, machine=3.
- R3: The supervisor group is `pend_i & deleg_i`. It is enabled when `priv_i` is user (0), or when `priv_i` is supervisor (1) and `s_ie_i` is 1. It is never enabled in machine mode.
- R4: The supervisor group is examined only when the enabled machine group is empty. A pending and enabled machine line therefore wins over any supervisor line, whatever its index.
- R5: Within the group that is examined, the selected line is the lowest set bit index.
- R6: When an interrupt is taken, `cause_o[XLEN-1]` is 1, `cause_o[$clog2(XLEN)-1:0]` holds the selected index, and all other bits are 0.
- R7: While `dbg_mode_i` is 1, no interrupt is taken: `take_o` is 0 after the edge and `cause_o` keeps its value.
- R8: When neither group yields an enabled pending line, `take_o` is 0 after the edge and `cause_o` keeps its previous value.
- R9: The outputs after a rising edge reflect the inputs sampled at that edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_i | input | XLEN | Pending interrupt lines, one bit per line |
| deleg_i | input | XLEN | Delegation mask; 1 sends the line to the supervisor group |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_ie_i | input | 1 | Machine global interrupt enable |
| s_ie_i | input | 1 | Supervisor global interrupt enable |
| dbg_mode_i | input | 1 | Hart is in debug mode |
| take_o | output | 1 | Registered strobe: an interrupt is taken |
| cause_o | output | XLEN | Registered cause word; MSB is the interrupt marker |

## Verification
The bench targets five corner cases.

The first is a delegated line with a lower index pending alongside a non-delegated line with a higher index. A selector that ignored group order would report the lower index.

The second is machine mode with the machine enable clear. A design that treated the enable as "at or below machine" would take the interrupt anyway.

The third is delegated lines pending while the hart is in machine mode. These must never be taken. A design that compared supervisor privilege the wrong way round would take them.

The fourth is debug mode with enabled lines pending, and the fifth is cycles with nothing enabled. In both, the cause must hold its value; a design that cleared or overwrote the cause would fail here.

Line 31 is also exercised, to catch a truncated index or a misplaced marker bit. A long random phase compares every cycle against a behavioural model.

// File: rtl/irq_sel_pkg.sv
// Package: shared privilege encoding for the interrupt selector.
// Assumes two-bit privilege values; the encoding 2 is reserved and is
// treated as "below machine, above supervisor".
package irq_sel_pkg;
    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;
endpackage

// File: rtl/irq_enable_gate.sv
// Module: irq_enable_gate
// Derives the global enable for each interrupt group from the privilege
// level and the two global enable bits. Purely combinational.
// Assumes privilege values are ordered user < supervisor < machine.
module irq_enable_gate
    import irq_sel_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       m_ie_i,
    input  logic       s_ie_i,
    output logic       m_en_o,
    output logic       s_en_o
);
    priv_e priv;

    // Enable rule: lower privilege always open, same level gated by its bit.
    always_comb begin
        priv   = priv_e'(priv_i);
        m_en_o = (priv != PRIV_MACH) || m_ie_i;
        s_en_o = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_ie_i);
    end
endmodule

// File: rtl/irq_group_pick.sv
// Module: irq_group_pick
// Splits pending lines into machine and supervisor groups and returns the
// enabled set to arbitrate on: the machine group if it is non-empty, the
// supervisor group otherwise. Combinational.
module irq_group_pick #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] deleg_i,
    input  logic         m_en_i,
    input  logic         s_en_i,
    output logic [W-1:0] grp_o,
    output logic         from_m_o
);
    logic [W-1:0] m_set;
    logic [W-1:0] s_set;

    // Group masks and machine-first fallback.
    always_comb begin
        m_set    = pend_i & ~deleg_i & {W{m_en_i}};
        s_set    = pend_i &  deleg_i & {W{s_en_i}};
        from_m_o = |m_set;
        grp_o    = from_m_o ? m_set : s_set;
    end
endmodule

// File: rtl/irq_lowest_index.sv
// Module: irq_lowest_index
// Finds the lowest set bit of a vector: one-hot form and binary index.
// Built from a prefix-OR chain so the depth grows linearly with W.
module irq_lowest_index #(
    parameter int unsigned W  = 32,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [W-1:0]  onehot_o,
    output logic [IW-1:0] idx_o
);
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_chain
            // Bit g wins only if no lower bit is set.
            assign onehot_o[g] = vec_i[g] & ~seen[g];
            assign seen[g+1]   = seen[g] | vec_i[g];
        end
    endgenerate

    assign any_o = seen[W];

    // Encode the one-hot winner into a binary index.
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot_o[i]) idx_o = idx_o | IW'(i);
        end
    end
endmodule

// File: rtl/irq_select_top.sv
// Module: irq_select_top
// Registered interrupt selector. Each cycle it evaluates pending lines,
// delegation, privilege and enables. It then registers a take strobe and a
// cause word (MSB marks an interrupt, low bits give the line index).
// Assumes XLEN is 32 or 64. The cause holds its value when nothing is taken.
module irq_select_top #(
    parameter int unsigned XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            m_ie_i,
    input  logic            s_ie_i,
    input  logic            dbg_mode_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int unsigned IW = $clog2(XLEN);

    logic            m_en, s_en;
    logic [XLEN-1:0] grp;
    logic            grp_from_m;
    logic            grp_any;
    logic [XLEN-1:0] sel_onehot;
    logic [IW-1:0]   sel_idx;
    logic            take_next;
    logic [XLEN-1:0] cause_next;

    irq_enable_gate u_gate (
        .priv_i (priv_i),
        .m_ie_i (m_ie_i),
        .s_ie_i (s_ie_i),
        .m_en_o (m_en),
        .s_en_o (s_en)
    );

    irq_group_pick #(.W(XLEN)) u_pick (
        .pend_i   (pend_i),
        .deleg_i  (deleg_i),
        .m_en_i   (m_en),
        .s_en_i   (s_en),
        .grp_o    (grp),
        .from_m_o (grp_from_m)
    );

    irq_lowest_index #(.W(XLEN), .IW(IW)) u_low (
        .vec_i    (grp),
        .any_o    (grp_any),
        .onehot_o (sel_onehot),
        .idx_o    (sel_idx)
    );

    // Next-state values: debug mode blocks the take, and the cause word is formed.
    always_comb begin
        take_next             = grp_any && !dbg_mode_i;
        cause_next            = '0;
        cause_next[XLEN-1]    = 1'b1;
        cause_next[IW-1:0]    = sel_idx;
    end

    // Output register: clear on reset, load cause only when taking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o  <= 1'b0;
            cause_o <= '0;
        end else begin
            take_o <= take_next;
            if (take_next) cause_o <= cause_next;
        end
    end

    // R2: machine level with its enable clear takes nothing.
    assert_mach_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'd3 && !m_ie_i) |=> !take_o);

    // R3: supervisor level, enable clear, no machine line pending -> nothing taken.
    assert_super_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == 2'd1 && !s_ie_i && ((pend_i & ~deleg_i) == '0)) |=> !take_o);

    // R4: an enabled machine-group line forces arbitration on the machine group.
    assert_mach_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_en && ((pend_i & ~deleg_i) != '0)) |-> grp_from_m);

    // R5: the winner is single and no lower bit of the group is set.
    assert_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_onehot) && ((grp & (sel_onehot - 1'b1)) == '0));

    // R6: a taken interrupt always carries the marker bit.
    assert_marker_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[XLEN-1]);

    // R7: debug mode blocks a take at the next edge.
    assert_debug_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_mode_i |=> !take_o);

    // R8: the cause word only changes together with a take.
    assert_cause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> $stable(cause_o));
endmodule

// File: tb/tb_irq_select_top.sv
`timescale 1ns/1ps
module tb_irq_select_top;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] pend, deleg;
    logic [1:0]      priv;
    logic            mie, sie, dbg;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic            exp_take;
    logic [XLEN-1:0] exp_cause;

    always #2 clk = ~clk;

    irq_select_top #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .deleg_i(deleg),
        .priv_i(priv), .m_ie_i(mie), .s_ie_i(sie), .dbg_mode_i(dbg),
        .take_o(take_o), .cause_o(cause_o)
    );

    // Behavioural model: search machine lines, then delegated lines, lowest first.
    task automatic model_step();
        bit m_ok = (priv != 2'd3) || mie;
        bit s_ok = (priv == 2'd0) || (priv == 2'd1 && sie);
        int pick = -1;
        if (!rst_n) begin
            exp_take = 0; exp_cause = '0;
            return;
        end
        for (int i = 0; i < XLEN; i++)
            if (pick < 0 && pend[i] && !deleg[i] && m_ok) pick = i;
        if (pick < 0)
            for (int i = 0; i < XLEN; i++)
                if (pick < 0 && pend[i] && deleg[i] && s_ok) pick = i;
        if (dbg || pick < 0) begin
            exp_take = 0;
        end else begin
            exp_take  = 1;
            exp_cause = (32'h1 << (XLEN - 1)) | pick;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (take_o !== exp_take || cause_o !== exp_cause) begin
            failures++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     tag, take_o, cause_o, exp_take, exp_cause);
        end
    endtask

    // One clock: model follows the edge, outputs sampled 1 ns later.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
    endtask

    task automatic apply(input logic [XLEN-1:0] p, input logic [XLEN-1:0] d,
                         input logic [1:0] pv, input logic m, input logic s,
                         input logic g, input string tag);
        pend = p; deleg = d; priv = pv; mie = m; sie = s; dbg = g;
        cycle(tag);
    endtask

    initial begin
        rst_n = 0; pend = '0; deleg = '0; priv = 2'd3; mie = 0; sie = 0; dbg = 0;
        exp_take = 0; exp_cause = '0;
        pend = 32'hFFFF_FFFF; mie = 1;      // busy inputs during reset
        cycle("R1 reset");
        cycle("R1 reset");
        rst_n = 1;
        apply(32'h20, 32'h0, 2'd3, 1, 0, 0, "R2 machine enabled / R6 cause=5");
        apply(32'h20, 32'h0, 2'd3, 0, 0, 0, "R2 machine masked / R8 hold");
        apply(32'h80, 32'h0, 2'd1, 0, 0, 0, "R2 below machine ignores enable");
        apply(32'h02, 32'h02, 2'd1, 1, 0, 0, "R3 supervisor masked");
        apply(32'h02, 32'h02, 2'd1, 0, 1, 0, "R3 supervisor enabled");
        apply(32'h200, 32'h200, 2'd0, 0, 0, 0, "R3 user takes delegated");
        apply(32'h02, 32'h02, 2'd3, 1, 1, 0, "R3 delegated never in machine");
        apply(32'h808, 32'h008, 2'd0, 0, 0, 0, "R4 machine group first");
        apply(32'hF0, 32'h0, 2'd3, 1, 0, 0, "R5 lowest index 4");
        apply(32'h8000_0000, 32'h0, 2'd3, 1, 0, 0, "R6 index 31");
        apply(32'h10, 32'h0, 2'd3, 1, 0, 1, "R7 debug blocks take");
        apply(32'h0, 32'h0, 2'd3, 1, 1, 0, "R8 nothing pending");
        apply(32'h4, 32'h0, 2'd3, 1, 0, 0, "R9 one-cycle latency");
        for (int n = 0; n < 3000; n++) begin
            pend  = $urandom() & $urandom();
            deleg = $urandom();
            priv  = 2'($urandom_range(0, 3));
            mie   = 1'($urandom());
            sie   = 1'($urandom());
            dbg   = ($urandom_range(0, 9) == 0);
            cycle("R9 random");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule